// File: doc/BRIEF.md
# Paced double-transition transmit sequencer

This block turns a byte stream into the line states of a parallel, double-transition bus running paced transfers. Whenever the transfer-period strobe `tick` lets a period go, it drives one byte on the data lines together with its parity bit, toggles the REQ/ACK line, and moves the phase-marker line P1. For every data, parity and REQ/ACK line that changed level in that period, it raises a boost flag. The analog driver uses that flag to drive the line harder for one period.

Upstream logic delivers each information unit as a valid/ready stream, with the first byte marked by `s_sof` and the last by `s_eof`. The sequencer measures each unit in four-byte groups and fills a short unit out with zero bytes. It then sends a 32-bit CRC of everything it transmitted. P1 stays level for the first two periods of a unit, which tells the receiver where valid data begins. After that, P1 flips on every other period.

Top module: `paced_dt_tx`

## Requirements
- R1: While `rst_n` is low, `bus_data`, `bus_par`, `bus_p1`, `bus_req`, `bus_boost` and `s_ready` are all 0.
- R2: `s_ready` is high only in a cycle with `tick` high, and only while the block is idle or taking payload. It stays low for every pad and CRC period of a unit.
- R3: Each transfer period updates the outputs one clock after the strobe. `bus_data` carries the byte, `bus_par` is chosen so that the 8 data bits plus parity hold an odd number of ones, and `bus_req` inverts.
- R4: In the first two periods of a unit (period indices 0 and 1), `bus_p1` keeps the level it had before the unit.
- R5: From period index 2 onward, `bus_p1` inverts in every period with an even index and holds in every period with an odd index.
- R6: `bus_boost[7:0]` flags the data lines, `bus_boost[8]` the parity line and `bus_boost[9]` REQ/ACK. A flag is 1 in a period where its line changed level and 0 in a period where the line kept its level. Between periods the flags hold.
- R7: If a unit's payload length is not a multiple of four, zero bytes follow the last payload byte until the total is a multiple of four.
- R8: After the payload and padding, four CRC bytes are sent, most significant byte first. The CRC uses the generator 0x04C11DB7, is preset to all ones, and is fed MSB-first over every payload and pad byte, with no final inversion.
- R9: A byte accepted while idle without `s_sof` is consumed and discarded, and no period is emitted for it.
- R10: Without `tick`, or while taking payload with `s_valid` low, no period is emitted and all bus outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Transfer-period strobe; one period may go per strobe cycle |
| s_valid | input | 1 | Upstream byte valid |
| s_ready | output | 1 | Upstream byte accepted this cycle when high with `s_valid` |
| s_data | input | 8 | Upstream byte |
| s_sof | input | 1 | Byte is the first of a unit |
| s_eof | input | 1 | Byte is the last of a unit |
| bus_data | output | 8 | Data lines |
| bus_par | output | 1 | Odd parity over `bus_data` |
| bus_p1 | output | 1 | Phase-marker line |
| bus_req | output | 1 | REQ/ACK line, inverts each period |
| bus_boost | output | 10 | Per-line boost flags: [7:0] data, [8] parity, [9] REQ/ACK |

## Verification
The bench covers units of one, five and eight bytes, so padding of three bytes, of three bytes and of none are all exercised. A wrong pad count would shift the CRC bytes and corrupt the CRC value. It sends runs of identical bytes to check that the boost flags clear. A block that never drops a flag, or that flags every line, fails those periods. It follows P1 across back-to-back units with different lengths, which catches a held start that lasts the wrong number of periods or a P1 that loses its level between units. It also stalls the strobe mid-unit and feeds a stray byte with no start marker to catch periods emitted when none should be.

// File: rtl/paced_dt_tx.sv
module paced_dt_tx #(
  parameter logic [31:0] POLY   = 32'h04C11DB7,
  parameter logic [31:0] PRESET = 32'hFFFF_FFFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_data,
  input  logic       s_sof,
  input  logic       s_eof,
  output logic [7:0] bus_data,
  output logic       bus_par,
  output logic       bus_p1,
  output logic       bus_req,
  output logic [9:0] bus_boost
);

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_PAD, ST_CRC} st_t;

  st_t         st;
  logic [1:0]  idx;
  logic        early;
  logic [31:0] crc;
  logic [7:0]  nb;

  wire idle = (st == ST_IDLE);
  assign s_ready = rst_n && tick && (idle || st == ST_DATA);
  wire take = s_ready && s_valid;
  wire emit = (take && (!idle || s_sof)) || (tick && (st == ST_PAD || st == ST_CRC));

  always_comb begin
    case (st)
      ST_PAD:  nb = 8'h00;
      ST_CRC:  nb = crc[31:24];
      default: nb = s_data;
    endcase
  end

  wire [1:0] k       = idle ? 2'd0 : idx;
  wire       early_k = idle || early;
  wire       p1_flip = !early_k && !k[0];
  wire       nxt_par = ~^nb;
  wire [31:0] seed   = idle ? PRESET : crc;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {b, 24'h0};
    for (int i = 0; i < 8; i++) r = r[31] ? ((r << 1) ^ POLY) : (r << 1);
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      idx <= 2'd0;
      early <= 1'b0;
      crc <= '0;
      bus_data <= '0;
      bus_par <= 1'b0;
      bus_p1 <= 1'b0;
      bus_req <= 1'b0;
      bus_boost <= '0;
    end else if (emit) begin
      bus_data  <= nb;
      bus_par   <= nxt_par;
      bus_req   <= ~bus_req;
      bus_p1    <= bus_p1 ^ p1_flip;
      bus_boost <= {1'b1, nxt_par ^ bus_par, nb ^ bus_data};
      idx       <= k + 2'd1;
      early     <= early_k && (k == 2'd0);
      crc       <= (st == ST_CRC) ? {crc[23:0], 8'h00} : crc_step(seed, nb);
      case (st)
        ST_IDLE, ST_DATA: if (s_eof) st <= (k == 2'd3) ? ST_CRC : ST_PAD;
                          else       st <= ST_DATA;
        ST_PAD:           if (k == 2'd3) st <= ST_CRC;
        default:          if (k == 2'd3) st <= ST_IDLE;
      endcase
    end
  end

  p_par_odd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_req) |-> (^{bus_data, bus_par}) == 1'b1);

  p_req_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && st == ST_DATA) |=> !$stable(bus_req));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(bus_data) && $stable(bus_req) && $stable(bus_p1)));

  p_no_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && st == ST_DATA && s_eof) |=> !s_ready);

  p_p1_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && idle) |=> $stable(bus_p1));

  p_boost_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_req) |-> (bus_boost[9] && bus_boost[7:0] == (bus_data ^ $past(bus_data))));

  p_boost_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(bus_req) |-> $stable(bus_boost));

endmodule

// File: tb/tb_paced_dt_tx.sv
module tb_paced_dt_tx;
  logic clk = 0;
  logic rst_n = 0;
  logic tick = 0;
  logic s_valid = 0, s_sof = 0, s_eof = 0;
  logic [7:0] s_data = 0;
  logic s_ready;
  logic [7:0] bus_data;
  logic bus_par, bus_p1, bus_req;
  logic [9:0] bus_boost;

  always #2 clk = ~clk;

  paced_dt_tx dut (.clk(clk), .rst_n(rst_n), .tick(tick), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_sof(s_sof), .s_eof(s_eof), .bus_data(bus_data), .bus_par(bus_par),
    .bus_p1(bus_p1), .bus_req(bus_req), .bus_boost(bus_boost));

  typedef struct packed {
    logic [7:0] d;
    logic       p;
    logic       p1;
    logic [9:0] b;
    logic       is_data;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  int tickmode = 1;
  int tcnt = 0;

  logic [7:0] m_data = 0;
  logic m_par = 0, m_req = 0, m_p1 = 0;
  int m_k = 0;
  logic [31:0] m_crc;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    tcnt++;
    tick <= (tickmode == 0) ? 1'b0 : (tickmode == 1) ? 1'b1 : (tcnt % 3 == 0);
  end

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[31] ^ b[i];
      r = {r[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
    end
    return r;
  endfunction

  task automatic push_period(input logic [7:0] b, input logic is_data);
    exp_t e;
    logic np;
    np = ~^b;
    if (m_k >= 2 && (m_k % 2) == 0) m_p1 = ~m_p1;
    e.d = b; e.p = np; e.p1 = m_p1; e.is_data = is_data;
    e.b = {1'b1, np ^ m_par, b ^ m_data};
    q.push_back(e);
    m_data = b; m_par = np; m_req = ~m_req;
    m_k++;
  endtask

  task automatic send_unit(input logic [7:0] bytes[$]);
    logic fire;
    m_k = 0;
    m_crc = 32'hFFFF_FFFF;
    for (int i = 0; i < bytes.size(); i++) begin
      fire = 0;
      while (!fire) begin
        @(negedge clk);
        s_valid = 1; s_data = bytes[i];
        s_sof = (i == 0); s_eof = (i == bytes.size() - 1);
        #1;
        fire = s_ready;
        if (fire) begin
          push_period(bytes[i], 1'b1);
          m_crc = crc_byte(m_crc, bytes[i]);
          if (i == bytes.size() - 1) begin
            while ((m_k % 4) != 0) begin
              push_period(8'h00, 1'b0);
              m_crc = crc_byte(m_crc, 8'h00);
            end
            for (int j = 3; j >= 0; j--) push_period(m_crc[j*8 +: 8], 1'b0);
          end
        end
        @(posedge clk);
      end
    end
    @(negedge clk);
    s_valid = 0; s_sof = 0; s_eof = 0;
  endtask

  logic last_req = 0;
  always begin
    @(negedge clk);
    #3;
    if (rst_n) begin
      if (bus_req !== last_req) begin
        last_req = bus_req;
        if (q.size() == 0) begin
          chk(1'b0, "R10 unexpected period", {24'h0, bus_data}, 32'h0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(bus_data === e.d, e.is_data ? "R3 data" : "R7/R8 pad or CRC byte", {24'h0, bus_data}, {24'h0, e.d});
          chk(bus_par === e.p, "R3 parity", {31'h0, bus_par}, {31'h0, e.p});
          chk(bus_p1 === e.p1, "R4/R5 p1", {31'h0, bus_p1}, {31'h0, e.p1});
          chk(bus_boost === e.b, "R6 boost", {22'h0, bus_boost}, {22'h0, e.b});
        end
      end
      if (q.size() != 0 && !q[0].is_data)
        chk(s_ready === 1'b0, "R2 ready low in pad/CRC", {31'h0, s_ready}, 32'h0);
    end
  end

  initial begin
    repeat (10000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic drain();
    wait (q.size() == 0);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [7:0] u[$];
    logic r0;
    repeat (4) @(negedge clk);
    #1;
    chk(bus_data === 0 && bus_par === 0 && bus_p1 === 0 && bus_req === 0, "R1 reset outputs",
        {22'h0, bus_data, bus_par, bus_p1, bus_req}, 32'h0);
    chk(bus_boost === 0 && s_ready === 0, "R1 reset boost/ready", {21'h0, bus_boost, s_ready}, 32'h0);
    @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    u = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC, 8'hDE, 8'hF0};
    send_unit(u);
    drain();

    tickmode = 2;
    u = '{8'hFF, 8'h00, 8'h3C, 8'hC3, 8'h81};
    send_unit(u);
    drain();

    tickmode = 1;
    u = '{8'h5A};
    send_unit(u);
    drain();

    u = '{8'hA5, 8'hA5, 8'hA5, 8'hA5};
    send_unit(u);
    drain();

    r0 = bus_req;
    @(negedge clk);
    s_valid = 1; s_sof = 0; s_eof = 0; s_data = 8'h77;
    #1;
    chk(s_ready === 1'b1, "R9 stray byte accepted", {31'h0, s_ready}, 32'h1);
    @(negedge clk);
    s_valid = 0;
    repeat (5) @(negedge clk);
    chk(bus_req === r0 && q.size() == 0, "R9 stray byte emits nothing", {31'h0, bus_req}, {31'h0, r0});

    u = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06};
    fork
      send_unit(u);
      begin
        repeat (3) @(negedge clk);
        tickmode = 0;
        repeat (2) @(negedge clk);
        r0 = bus_req;
        repeat (10) @(negedge clk);
        #3;
        chk(bus_req === r0, "R10 hold without strobe", {31'h0, bus_req}, {31'h0, r0});
        tickmode = 1;
      end
    join
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule